// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns the programmed base registers of a configuration header into a set of address windows. There are six general base registers and one expansion-ROM register. Each region has a size and a space type (memory or I/O), both fixed by parameters. A two-bit space-enable input carries the I/O and memory enable bits of the command word. Whenever the remap strobe is pulsed, the block recomputes every window: its aligned base, its last address and whether it is legal. It keeps the result in registers until the next strobe.

An incoming transaction address, together with a flag that says memory or I/O, is compared against the stored windows. The block reports a hit and the index of the winning region. The ROM region answers as index 6. For one cycle after each remap, the block also raises a per-region change flag for every window whose base or validity moved. A system model can use this flag to observe map and unmap events.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every window is invalid, `win_valid` is 0, `hit` is 0 and `changed` is 0.
- R2: An I/O region can be valid only if `space_en[0]` was 1 at the remap that computed it.
- R3: A memory region (including the ROM region) can be valid only if `space_en[1]` was 1 at the remap that computed it.
- R4: The ROM region (index 6) can be valid only if bit 0 of `rom_val` was 1 at the remap.
- R5: The effective base is the register value with its bits below log2(size) cleared. A valid window hits for every address from base to base+size-1 inclusive, and misses just outside that range.
- R6: A window whose effective base is zero, or whose last address is not above its base, is invalid.
- R7: An I/O window whose last address is 0x10000 or above is invalid. A last address of 0xFFFF is allowed.
- R8: A memory window whose last address is 0xFFFFFFFF is invalid.
- R9: A region whose size parameter is zero is never valid and never hits.
- R10: A hit requires `lookup_io` to match the region type: 1 for I/O, 0 for memory. The ROM region is always memory.
- R11: When several valid windows contain the address, `hit_idx` is the lowest index; base register n is index n, and the ROM is index 6. When there is no hit, `hit_idx` is 0.
- R12: In the cycle after a remap, `changed[i]` is 1 exactly when window i's effective base or valid flag differs from the value it held before. `changed` is 0 in every other cycle.
- R13: Windows, and therefore `win_valid` and the hit result, change only at a remap. Register inputs that change without a strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| space_en | input | 2 | Bit 0: I/O space enable, bit 1: memory space enable |
| bar_vals | input | 192 | Six 32-bit base register values, register n at bits [32n+31:32n] |
| rom_val | input | 32 | ROM base register value; bit 0 is the ROM enable |
| remap | input | 1 | Recompute all windows at this clock edge |
| lookup_addr | input | 32 | Transaction address to decode |
| lookup_io | input | 1 | 1 for an I/O transaction, 0 for memory |
| hit | output | 1 | Some valid window of the right space contains the address |
| hit_idx | output | 3 | Index of the winning region (0..6) |
| win_valid | output | 7 | Valid flag of each stored window |
| changed | output | 7 | One-cycle per-region change flags after a remap |

## Verification
The bench probes each window at its first and last address and one address past each end. A decoder that got the size mask or the inclusive bound wrong would then either miss an edge address or claim a neighbour. It places I/O windows at exactly 0xFFE0 and 0x10000, and a memory window ending at all ones, so that an off-by-one in the limit tests would mark the wrong one legal. It overlaps a base register with a larger region and with the ROM to catch a reversed priority. It also repeats a remap with unchanged inputs, to catch a change detector that fires on every strobe rather than on a real difference.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

    localparam int AW        = 32;
    localparam int NUM_BAR   = 6;
    localparam int ROM_IDX   = NUM_BAR;
    localparam int NREG      = NUM_BAR + 1;
    localparam int IDX_W     = $clog2(NREG);
    localparam int IO_EN_BIT = 0;
    localparam int MEM_EN_BIT = 1;
    localparam logic [AW-1:0] IO_LIMIT = 32'h0001_0000;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] last;
        logic          valid;
    } win_t;

    // Derive one window from its raw register value and static attributes.
    function automatic win_t eval_window(
        input logic [AW-1:0] raw,
        input logic [AW-1:0] size,
        input logic          is_io,
        input logic          is_rom,
        input logic [1:0]    en
    );
        win_t          w;
        logic [AW-1:0] b;
        logic [AW-1:0] l;
        logic          ok;
        b  = raw & ~(size - 1'b1);
        l  = b + size - 1'b1;
        ok = (size != '0);
        if (is_io) begin
            ok = ok && en[IO_EN_BIT] && (l < IO_LIMIT);
        end else begin
            ok = ok && en[MEM_EN_BIT] && (l != '1);
        end
        if (is_rom) begin
            ok = ok && raw[0];
        end
        ok = ok && (b != '0) && (l > b);
        w.valid = ok;
        w.base  = ok ? b : '1;
        w.last  = ok ? l : '1;
        return w;
    endfunction

endpackage

// File: rtl/bar_window_eval.sv
module bar_window_eval
    import bar_dec_pkg::*;
#(
    parameter logic [NREG*AW-1:0] REGION_SIZE = '0,
    parameter logic [NREG-1:0]    IO_EFF      = '0
) (
    input  logic [1:0]         space_en,
    input  logic [NUM_BAR*AW-1:0] bar_vals,
    input  logic [AW-1:0]      rom_val,
    output win_t [NREG-1:0]    next_wins
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [AW-1:0] SZ = REGION_SIZE[g*AW +: AW];
        if (g == ROM_IDX) begin : g_rom
            assign next_wins[g] = eval_window(rom_val, SZ, 1'b0, 1'b1, space_en);
        end else begin : g_bar
            assign next_wins[g] = eval_window(bar_vals[g*AW +: AW], SZ,
                                              IO_EFF[g], 1'b0, space_en);
        end
    end

endmodule

// File: rtl/bar_window_store.sv
module bar_window_store
    import bar_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            remap,
    input  win_t [NREG-1:0] next_wins,
    output win_t [NREG-1:0] cur_wins,
    output logic [NREG-1:0] changed
);

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cur_wins[g].base  <= '1;
                cur_wins[g].last  <= '1;
                cur_wins[g].valid <= 1'b0;
                changed[g]        <= 1'b0;
            end else if (remap) begin
                cur_wins[g] <= next_wins[g];
                changed[g]  <= (next_wins[g].base != cur_wins[g].base) ||
                               (next_wins[g].valid != cur_wins[g].valid);
            end else begin
                changed[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bar_hit_select.sv
module bar_hit_select
    import bar_dec_pkg::*;
#(
    parameter logic [NREG-1:0] IO_EFF = '0
) (
    input  win_t [NREG-1:0]  cur_wins,
    input  logic [AW-1:0]    lookup_addr,
    input  logic             lookup_io,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    logic [NREG-1:0] cand;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign cand[g] = cur_wins[g].valid &&
                         (lookup_io == IO_EFF[g]) &&
                         (lookup_addr >= cur_wins[g].base) &&
                         (lookup_addr <= cur_wins[g].last);
    end

    always_comb begin
        hit     = |cand;
        hit_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (cand[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bar_dec_pkg::*;
#(
    parameter logic [NREG*AW-1:0] REGION_SIZE = {
        32'h0000_8000,   // ROM
        32'h0001_0000,   // 5
        32'h0000_0100,   // 4
        32'h0000_0000,   // 3 (absent)
        32'h0010_0000,   // 2
        32'h0000_1000,   // 1
        32'h0000_0020    // 0
    },
    parameter logic [NREG-1:0] IO_MASK = 7'b001_0001
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            space_en,
    input  logic [NUM_BAR*AW-1:0] bar_vals,
    input  logic [AW-1:0]         rom_val,
    input  logic                  remap,
    input  logic [AW-1:0]         lookup_addr,
    input  logic                  lookup_io,
    output logic                  hit,
    output logic [IDX_W-1:0]      hit_idx,
    output logic [NREG-1:0]       win_valid,
    output logic [NREG-1:0]       changed
);

    localparam logic [NREG-1:0] IO_EFF = IO_MASK & ~(NREG'(1) << ROM_IDX);

    win_t [NREG-1:0] next_wins;
    win_t [NREG-1:0] cur_wins;

    bar_window_eval #(
        .REGION_SIZE(REGION_SIZE),
        .IO_EFF     (IO_EFF)
    ) eval_i (
        .space_en (space_en),
        .bar_vals (bar_vals),
        .rom_val  (rom_val),
        .next_wins(next_wins)
    );

    bar_window_store store_i (
        .clk      (clk),
        .rst      (rst),
        .remap    (remap),
        .next_wins(next_wins),
        .cur_wins (cur_wins),
        .changed  (changed)
    );

    bar_hit_select #(
        .IO_EFF(IO_EFF)
    ) sel_i (
        .cur_wins   (cur_wins),
        .lookup_addr(lookup_addr),
        .lookup_io  (lookup_io),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_vld
        assign win_valid[g] = cur_wins[g].valid;
    end

endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk
    import bar_dec_pkg::*;
#(
    parameter logic [NREG-1:0] IO_MASK = '0
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       space_en,
    input logic [AW-1:0]    rom_val,
    input logic             remap,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx,
    input logic [NREG-1:0]  win_valid,
    input logic [NREG-1:0]  changed
);

    localparam logic [NREG-1:0] IO_T = IO_MASK & ~(NREG'(1) << ROM_IDX);

    AST_CHANGED_NEEDS_REMAP: assert property (@(posedge clk) disable iff (rst)
        (changed != '0) |-> $past(remap)) else $error("changed without remap"); // R12

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !remap |=> $stable(win_valid)) else $error("window moved without remap"); // R13

    AST_HIT_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        hit |-> win_valid[hit_idx]) else $error("hit on invalid window"); // R11

    AST_NO_WINDOW_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (win_valid == '0) |-> !hit) else $error("hit with no window"); // R1

    AST_IO_GATED: assert property (@(posedge clk) disable iff (rst)
        ($past(remap) && !$past(space_en[IO_EN_BIT])) |-> ((win_valid & IO_T) == '0))
        else $error("io window despite disable"); // R2

    AST_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
        ($past(remap) && !$past(space_en[MEM_EN_BIT])) |-> ((win_valid & ~IO_T) == '0))
        else $error("memory window despite disable"); // R3

    AST_ROM_GATED: assert property (@(posedge clk) disable iff (rst)
        ($past(remap) && !$past(rom_val[0])) |-> !win_valid[ROM_IDX])
        else $error("rom window despite enable bit low"); // R4

endmodule

bind bar_window_decoder bar_window_decoder_chk #(.IO_MASK(IO_MASK)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .space_en (space_en),
    .rom_val  (rom_val),
    .remap    (remap),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .win_valid(win_valid),
    .changed  (changed)
);

// File: tb/bar_window_decoder_tb.sv
module bar_window_decoder_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   space_en;
    logic [191:0] bar_vals;
    logic [31:0]  rom_val;
    logic         remap;
    logic [31:0]  lookup_addr;
    logic         lookup_io;
    logic         hit;
    logic [2:0]   hit_idx;
    logic [6:0]   win_valid;
    logic [6:0]   changed;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    bar_window_decoder dut_i (
        .clk(clk), .rst(rst), .space_en(space_en), .bar_vals(bar_vals),
        .rom_val(rom_val), .remap(remap), .lookup_addr(lookup_addr),
        .lookup_io(lookup_io), .hit(hit), .hit_idx(hit_idx),
        .win_valid(win_valid), .changed(changed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_bar(input int n, input logic [31:0] v);
        bar_vals[n*32 +: 32] = v;
    endtask

    // Pulse remap for one edge; returns at the following negedge.
    task automatic do_remap();
        remap = 1'b1;
        @(posedge clk);
        @(negedge clk);
        remap = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] a, input logic io,
                        input logic eh, input logic [2:0] ei);
        lookup_addr = a;
        lookup_io   = io;
        #1;
        chk({req, " hit"}, {31'b0, hit}, {31'b0, eh});
        if (eh) chk({req, " idx"}, {29'b0, hit_idx}, {29'b0, ei});
    endtask

    task automatic t_reset();
        chk("R1 valid", {25'b0, win_valid}, 32'h0);
        chk("R1 changed", {25'b0, changed}, 32'h0);
        look("R1", 32'h0000_1000, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_basic();
        space_en = 2'b11;
        set_bar(0, 32'h0000_1001);
        set_bar(1, 32'h8000_0123);
        do_remap();
        chk("R12 changed first", {25'b0, changed}, 32'h03);
        chk("R5 valid", {25'b0, win_valid}, 32'h03);
        look("R5 io lo", 32'h0000_1000, 1'b1, 1'b1, 3'd0);
        look("R5 io hi", 32'h0000_101F, 1'b1, 1'b1, 3'd0);
        look("R5 io past", 32'h0000_1020, 1'b1, 1'b0, 3'd0);
        look("R5 io below", 32'h0000_0FFF, 1'b1, 1'b0, 3'd0);
        look("R5 mem lo", 32'h8000_0000, 1'b0, 1'b1, 3'd1);
        look("R5 mem hi", 32'h8000_0FFF, 1'b0, 1'b1, 3'd1);
        look("R5 mem past", 32'h8000_1000, 1'b0, 1'b0, 3'd0);
        look("R10 io vs mem", 32'h0000_1000, 1'b0, 1'b0, 3'd0);
        look("R10 mem vs io", 32'h8000_0000, 1'b1, 1'b0, 3'd0);
        @(negedge clk);
        chk("R12 pulse ends", {25'b0, changed}, 32'h0);
        do_remap();
        chk("R12 same inputs", {25'b0, changed}, 32'h0);
    endtask

    task automatic t_hold();
        set_bar(0, 32'h0000_2000);
        @(negedge clk);
        @(negedge clk);
        look("R13 old base kept", 32'h0000_1000, 1'b1, 1'b1, 3'd0);
        look("R13 new base unused", 32'h0000_2000, 1'b1, 1'b0, 3'd0);
        do_remap();
        chk("R12 base move", {25'b0, changed}, 32'h01);
        look("R13 new base live", 32'h0000_2000, 1'b1, 1'b1, 3'd0);
    endtask

    task automatic t_enables();
        space_en = 2'b10;
        do_remap();
        chk("R2 io off", {25'b0, win_valid}, 32'h02);
        chk("R12 unmap", {25'b0, changed}, 32'h01);
        space_en = 2'b01;
        do_remap();
        chk("R3 mem off", {25'b0, win_valid}, 32'h01);
        look("R3 mem miss", 32'h8000_0000, 1'b0, 1'b0, 3'd0);
        space_en = 2'b11;
        do_remap();
        chk("R2 R3 both on", {25'b0, win_valid}, 32'h03);
    endtask

    task automatic t_rom();
        rom_val = 32'h000A_0000;
        do_remap();
        chk("R4 rom disabled", {31'b0, win_valid[6]}, 32'h0);
        rom_val = 32'h000A_0001;
        do_remap();
        chk("R4 rom enabled", {31'b0, win_valid[6]}, 32'h1);
        look("R4 rom lo", 32'h000A_0000, 1'b0, 1'b1, 3'd6);
        look("R4 rom hi", 32'h000A_7FFF, 1'b0, 1'b1, 3'd6);
        look("R10 rom io", 32'h000A_0000, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_limits();
        set_bar(0, 32'h0000_FFE0);
        set_bar(2, 32'hFFF0_0000);
        set_bar(3, 32'h4000_0000);
        set_bar(4, 32'h0000_0000);
        do_remap();
        chk("R7 io at 0xFFFF ok", {31'b0, win_valid[0]}, 32'h1);
        look("R7 io top", 32'h0000_FFFF, 1'b1, 1'b1, 3'd0);
        chk("R8 mem all ones", {31'b0, win_valid[2]}, 32'h0);
        chk("R9 size zero", {31'b0, win_valid[3]}, 32'h0);
        look("R9 size zero miss", 32'h4000_0000, 1'b0, 1'b0, 3'd0);
        chk("R6 zero base io", {31'b0, win_valid[4]}, 32'h0);
        set_bar(0, 32'h0001_0000);
        set_bar(2, 32'hFFE0_0000);
        do_remap();
        chk("R7 io over 64K", {31'b0, win_valid[0]}, 32'h0);
        chk("R8 mem below top", {31'b0, win_valid[2]}, 32'h1);
        look("R8 mem top-1", 32'hFFEF_FFFF, 1'b0, 1'b1, 3'd2);
    endtask

    task automatic t_priority();
        set_bar(5, 32'h8000_0000);
        rom_val = 32'h8000_8001;
        do_remap();
        look("R11 bar1 over bar5", 32'h8000_0000, 1'b0, 1'b1, 3'd1);
        look("R11 bar5 over rom", 32'h8000_8000, 1'b0, 1'b1, 3'd5);
        set_bar(1, 32'h0000_0000);
        do_remap();
        chk("R6 zero base mem", {31'b0, win_valid[1]}, 32'h0);
        look("R11 bar5 after bar1 gone", 32'h8000_0000, 1'b0, 1'b1, 3'd5);
        set_bar(5, 32'h0000_0000);
        do_remap();
        look("R11 rom alone", 32'h8000_8000, 1'b0, 1'b1, 3'd6);
    endtask

    initial begin
        rst = 1'b1; remap = 1'b0; space_en = 2'b00;
        bar_vals = '0; rom_val = '0; lookup_addr = '0; lookup_io = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_hold();
        t_enables();
        t_rom();
        t_limits();
        t_priority();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule